// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit numbers one multiplier bit at a time and gives a 2W-bit product. The host puts an operand on a shared input bus and pulses one of two load strobes. One strobe writes the multiplicand register, the other writes the multiplier register. The host then pulses `go`. A controller with three states walks through W iterations, and each iteration takes two clock cycles. In the first cycle the multiplicand is added into the upper accumulator when the multiplier's low bit is set. In the second cycle the carry, accumulator and multiplier shift right together as one register, and an iteration counter counts down.

The controller states are IDLE (code 00), ADD (code 01) and SHIFT (code 10). Code 11 is not used. These are the transitions:
- IDLE to ADD when `go` is high.
- IDLE to IDLE when `go` is low.
- ADD to SHIFT, always.
- SHIFT to ADD when the counter was not zero before the decrement.
- SHIFT to IDLE when it was zero.
- The unused code 11 goes to IDLE.

The product is read from the concatenation of the accumulator and the multiplier register. It stays unchanged in IDLE until the multiplier register is loaded again.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters IDLE and clears the carry, the accumulator and the counter. After that edge `busy` and `done` are 0 and `product[2W-1:W]` is 0.
- R2: A pulse on `ld_mplier` copies `din` into the multiplier register, so `product[W-1:0]` equals it after the edge. A pulse on `ld_mcand` copies `din` into the multiplicand register. Both strobes act whatever the controller state is.
- R3: When `go` is high at an edge in IDLE, the state becomes ADD. From the next cycle `busy` is 1 and `product[2W-1:W]` is 0.
- R4: When the multiply ends, `product` equals the multiplicand times the multiplier as an unsigned 2W-bit value.
- R5: `busy` stays high for exactly 2W cycles, with ADD and SHIFT alternating. `done` is 1 for the single cycle after the exit from SHIFT to IDLE, and 0 otherwise.
- R6: A carry out of the add is held in the carry bit and shifted back into the accumulator, so all-ones operands give the correct product. The shift always leaves the carry at 0.
- R7: A `go` pulse while `busy` is high has no effect. The run length and the product do not change.
- R8: In IDLE the product holds its value across cycles, and loading the multiplicand does not change it.
- R9: A zero operand gives a zero product.
- R10: With `go` low in IDLE, the block stays idle and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Shared operand bus |
| ld_mcand | input | 1 | Load strobe for the multiplicand register |
| ld_mplier | input | 1 | Load strobe for the multiplier register |
| go | input | 1 | Start request, sampled in IDLE |
| busy | output | 1 | High in ADD and SHIFT |
| done | output | 1 | One-cycle pulse after completion |
| product | output | 2W | Accumulator concatenated with the multiplier register |

## Verification
A load strobe shows up in `product[W-1:0]` one edge after it is sampled. A `go` sampled in IDLE raises `busy` and clears the upper half one edge later. The final product and the `done` pulse appear 2W edges after the `go` edge, and `done` falls one edge after that. The bench drives inputs on the falling edge and samples 1 ns after each rising edge. It counts rising edges from the `go` edge, so every check falls in the exact cycle these latencies predict.

// File: rtl/mult_pkg.sv
package mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ADD   = 2'b01,
        ST_SHIFT = 2'b10
    } mstate_t;
endpackage

// File: rtl/mult_iter_cnt.sv
module mult_iter_cnt #(
    parameter int W = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic is_zero
);
    localparam logic [CW-1:0] START_VAL = CW'(W - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= START_VAL;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);

    // R5: a fresh start reloads the full iteration count
    a_r5_cnt_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == START_VAL));
    // R5: each shift step lowers the count by one
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !is_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         ld_mcand,
    input  logic         ld_mplier,
    input  logic         init,
    input  logic         add_en,
    input  logic         clr_c,
    input  logic         shift_dec,
    output logic         q_lsb,
    output logic [2*W-1:0] product
);
    logic [W-1:0] b_q, a_q, q_q;
    logic         c_q;
    logic [W-1:0] sum;
    logic [W:0]   carry;

    // ripple-carry parallel adder A + B
    assign carry[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = a_q[i] ^ b_q[i] ^ carry[i];
        assign carry[i+1] = (a_q[i] & b_q[i]) | (carry[i] & (a_q[i] ^ b_q[i]));
    end

    always_ff @(posedge clk) begin
        if (ld_mcand) b_q <= din;
    end

    always_ff @(posedge clk) begin
        if (ld_mplier)      q_q <= din;
        else if (shift_dec) q_q <= {a_q[0], q_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            c_q <= 1'b0;
        end else begin
            if (init)           a_q <= '0;
            else if (add_en)    a_q <= sum;
            else if (shift_dec) a_q <= {c_q, a_q[W-1:1]};

            if (clr_c)          c_q <= 1'b0;
            else if (add_en)    c_q <= carry[W];
        end
    end

    assign q_lsb   = q_q[0];
    assign product = {a_q, q_q};

    // R3: starting a multiply empties the accumulator
    a_r3_init_clears: assert property (@(posedge clk) disable iff (rst)
        init |=> (a_q == '0));
    // R6: the shift step always leaves the carry cleared
    a_r6_carry_cleared: assert property (@(posedge clk) disable iff (rst)
        shift_dec |=> (c_q == 1'b0));
    // R8: with no load and no shift the multiplier register holds
    a_r8_q_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld_mplier && !shift_dec) |=> $stable(q_q));
    // R8: with no control active the accumulator holds
    a_r8_a_hold: assert property (@(posedge clk) disable iff (rst)
        (!init && !add_en && !shift_dec) |=> $stable(a_q));
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic q_lsb,
    input  logic p_zero,
    output logic init,
    output logic add_en,
    output logic clr_c,
    output logic shift_dec,
    output logic busy,
    output logic done
);
    mstate_t state_q, state_d;
    logic    done_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = go ? ST_ADD : ST_IDLE;
            ST_ADD:   state_d = ST_SHIFT;
            ST_SHIFT: state_d = p_zero ? ST_IDLE : ST_ADD;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SHIFT) && p_zero;
        end
    end

    always_comb begin
        init      = 1'b0;
        add_en    = 1'b0;
        clr_c     = 1'b0;
        shift_dec = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                init  = go;
                clr_c = go;
            end
            ST_ADD: add_en = q_lsb;
            ST_SHIFT: begin
                clr_c     = 1'b1;
                shift_dec = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (state_q == ST_ADD) || (state_q == ST_SHIFT);
    assign done = done_q;

    // R5: done lasts exactly one cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5: every add step is followed by a shift step
    a_r5_add_then_shift: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADD) |=> (state_q == ST_SHIFT));
    // R3: go in IDLE starts the run
    a_r3_go_starts: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && go) |=> busy);
    // R10: no go keeps the block idle
    a_r10_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !go) |=> !busy);
    // R7: go in the middle of a run does not restart it
    a_r7_go_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADD && go) |=> (state_q == ST_SHIFT));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   din,
    input  logic           ld_mcand,
    input  logic           ld_mplier,
    input  logic           go,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic init, add_en, clr_c, shift_dec, q_lsb, p_zero;

    mult_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .q_lsb     (q_lsb),
        .p_zero    (p_zero),
        .init      (init),
        .add_en    (add_en),
        .clr_c     (clr_c),
        .shift_dec (shift_dec),
        .busy      (busy),
        .done      (done)
    );

    mult_iter_cnt #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (init),
        .dec     (shift_dec),
        .is_zero (p_zero)
    );

    mult_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .ld_mcand  (ld_mcand),
        .ld_mplier (ld_mplier),
        .init      (init),
        .add_en    (add_en),
        .clr_c     (clr_c),
        .shift_dec (shift_dec),
        .q_lsb     (q_lsb),
        .product   (product)
    );

    // R1: the accumulator half reads zero right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (product[2*W-1:W] == '0 && !busy && !done));
endmodule

// File: tb/test_shiftadd_mult.sv
module test_shiftadd_mult;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [W-1:0]   din;
    logic           ld_mcand, ld_mplier, go;
    logic           busy, done;
    logic [2*W-1:0] product;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shiftadd_mult #(.W(W)) i_shiftadd_mult (
        .clk(clk), .rst(rst), .din(din), .ld_mcand(ld_mcand),
        .ld_mplier(ld_mplier), .go(go), .busy(busy), .done(done),
        .product(product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        ld_mcand = 0; ld_mplier = 0; go = 0;
    endtask

    task automatic load_ops(input logic [W-1:0] mc, input logic [W-1:0] mp);
        @(negedge clk); din = mc; ld_mcand = 1;
        tick();
        @(negedge clk); ld_mcand = 0; din = mp; ld_mplier = 1;
        tick();
        check(product[W-1:0] == mp, "R2 multiplier load", product[W-1:0], mp);
        drive_idle();
    endtask

    // go at one edge, then count busy cycles; optional stray go mid-run
    task automatic run_mult(input logic [W-1:0] mc, input logic [W-1:0] mp, input bit stray_go);
        int cnt;
        longint expv;
        expv = longint'(mc) * longint'(mp);
        load_ops(mc, mp);
        @(negedge clk); go = 1;
        tick();
        check(busy == 1'b1, "R3 busy after go", busy, 1);
        check(product[2*W-1:W] == 0, "R3 accumulator cleared", product[2*W-1:W], 0);
        @(negedge clk); go = 0;
        cnt = 1;
        for (int k = 0; k < 4*W; k++) begin
            if (stray_go && k == 3) begin
                @(negedge clk); go = 1;
            end else if (stray_go && k == 4) begin
                @(negedge clk); go = 0;
            end
            tick();
            if (!busy) break;
            cnt++;
            check(done == 1'b0, "R5 done low while busy", done, 0);
        end
        check(cnt == 2*W, stray_go ? "R7 run length with stray go" : "R5 busy length",
              cnt, 2*W);
        check(done == 1'b1, "R5 done pulse", done, 1);
        check(product == expv[2*W-1:0], stray_go ? "R7 product with stray go" : "R4 product",
              product, expv);
        tick();
        check(done == 1'b0, "R5 done falls", done, 0);
        check(busy == 1'b0, "R7 no restart", busy, 0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1; ld_mcand = 0; ld_mplier = 0; go = 0; din = '0;
        tick(); tick();
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(product[2*W-1:W] == 0, "R1 accumulator after reset", product[2*W-1:W], 0);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_idle_no_go();
        for (int k = 0; k < 6; k++) begin
            tick();
            check(busy == 0, "R10 idle without go", busy, 0);
        end
    endtask

    task automatic t_hold();
        logic [2*W-1:0] snap;
        run_mult(8'hA5, 8'h3C, 1'b0);
        snap = product;
        for (int k = 0; k < 5; k++) tick();
        check(product == snap, "R8 product holds", product, snap);
        @(negedge clk); din = 8'h77; ld_mcand = 1;
        tick();
        drive_idle();
        tick();
        check(product == snap, "R8 mcand load keeps product", product, snap);
    endtask

    task automatic t_carry();
        run_mult(8'hFF, 8'hFF, 1'b0);
        check(product == 16'hFE01, "R6 all-ones product", product, 16'hFE01);
    endtask

    task automatic t_zero();
        run_mult(8'h00, 8'hD3, 1'b0);
        check(product == 0, "R9 zero multiplicand", product, 0);
        run_mult(8'hC7, 8'h00, 1'b0);
        check(product == 0, "R9 zero multiplier", product, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R5 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1; din = '0; ld_mcand = 0; ld_mplier = 0; go = 0;
        t_reset();
        t_idle_no_go();
        run_mult(8'h05, 8'h03, 1'b0);
        run_mult(8'h80, 8'h01, 1'b0);
        run_mult(8'h01, 8'h80, 1'b0);
        t_carry();
        t_zero();
        run_mult(8'h9B, 8'hE6, 1'b1);
        t_hold();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule